// File: doc/BRIEF.md
# Invalidation Queue Descriptor Fetcher

This block is the hardware consumer of a circular invalidation queue that software builds in system memory. Software programs a queue base address and a 3-bit size code, enables the queue, and publishes new work by moving the tail pointer. The block owns the head pointer. Whenever the ring holds entries, the block reads the 16-byte descriptor at the head through a single-outstanding memory read port. It checks the type field and offers each legal descriptor to a downstream dispatcher. Head moves on only after the dispatcher has taken the entry.

When a fetched descriptor carries a type the block does not know, nothing is dispatched. The block freezes the queue and raises a sticky fault. Head keeps pointing at the offending entry, so software can read it back, repair it, and then restart the queue by clearing the fault.

Both stream interfaces use valid/ready. A memory request (`mem_req`) keeps its address until `mem_req_rdy` is seen high on a clock edge. Only one read is outstanding, and its response (`mem_rsp_vld`) is always accepted. A dispatch offer (`dsc_valid`) keeps its contents unchanged until `dsc_ready` is seen high on a clock edge. Register writes are single-cycle strobes with no handshake.

Top module: `invq_fetcher`

## Requirements
- R1: After reset, head and tail are 0, the queue is disabled, the fault flag is clear, and neither `mem_req` nor `dsc_valid` is asserted.
- R2: A write with `reg_sel`=0 (queue address) loads the size code from bits 2:0 and the page-aligned base from bits 47:12. The ring then holds 2^(code+8) entries, with the code clamped to MAX_QS. The same write returns head and tail to 0.
- R3: A write with `reg_sel`=1 loads the tail entry index from bits 18:4. Index bits at or above the current ring size are dropped. `tail_off` reports that index times 16.
- R4: A read is requested one cycle after the block is idle, enabled (`reg_sel`=2, bit 0), fault-free and head differs from tail. The request address is base + 16 × head. No other read is requested until the current one has been answered.
- R5: A pending request keeps `mem_req` and `mem_addr` steady until `mem_req_rdy` is high at a clock edge. The response is taken on the first cycle with `mem_rsp_vld` high after that edge. Bits 63:0 of the response are the low word and bits 127:64 are the high word.
- R6: A legal descriptor is offered on the cycle after its response. It is presented on `dsc_lo`/`dsc_hi`, with `dsc_type` equal to low-word bits 3:0. The offer stays valid and stable until `dsc_ready` is high.
- R7: Head advances by one entry, modulo the ring size, exactly on a dispatch handshake, and at no other time except the reset of R2. `head_off` reports head × 16.
- R8: A descriptor type of 0 or 6..15 is never dispatched. It sets `fault` on the next cycle, leaves head on that entry, and blocks all further reads.
- R9: A write with `reg_sel`=3 and bit 0 set clears the fault. Fetching then resumes from head. The fault stays set without such a write.
- R10: Clearing the enable bit stops new reads, but a descriptor already being fetched is still completed and dispatched.
- R11: After the last entry of the ring is dispatched, head wraps to entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 queue address, 1 tail, 2 enable, 3 fault clear |
| reg_wdata | input | 64 | Register write data |
| head_off | output | 19 | Head position as a byte offset (entry × 16) |
| tail_off | output | 19 | Tail position as a byte offset (entry × 16) |
| fault | output | 1 | Sticky illegal-descriptor fault |
| mem_req | output | 1 | Memory read request valid |
| mem_req_rdy | input | 1 | Memory read request ready |
| mem_addr | output | 48 | Byte address of the descriptor to read |
| mem_rsp_vld | input | 1 | Read response valid |
| mem_rsp_data | input | 128 | Read response data, high word in 127:64 |
| dsc_valid | output | 1 | Descriptor offered to the dispatcher |
| dsc_ready | input | 1 | Dispatcher accepts the descriptor |
| dsc_type | output | 4 | Type field of the offered descriptor |
| dsc_lo | output | 64 | Low word of the offered descriptor |
| dsc_hi | output | 64 | High word of the offered descriptor |

## Verification
A register write shows up on `head_off`/`tail_off` one cycle after its strobe edge. A read request appears one cycle after the ring becomes non-empty while the block is idle. A legal descriptor is offered the cycle after its response, and head moves on the cycle after the dispatch handshake. An illegal type sets `fault` the cycle after its response. The bench keeps a behavioural model in step with the design: the model advances at each rising edge using the inputs the bench drove at the previous falling edge. Every output is then compared at the following falling edge, so each result is checked in exactly the cycle it is due, under random memory and dispatch back-pressure and random response latency.

// File: rtl/invq_pkg.sv
package invq_pkg;

  localparam int WORD_W    = 64;
  localparam int DSC_W     = 2 * WORD_W;
  localparam int TYPE_W    = 4;
  localparam int ENT_SH    = 4;
  localparam int PAGE_SH   = 12;
  localparam int QS_W      = 3;
  localparam int QS_BASE   = 8;
  localparam int TYPE_LO   = 1;
  localparam int TYPE_HI   = 5;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_WAIT = 2'd2,
    FS_SEND = 2'd3
  } fetch_st_e;

  typedef enum logic [1:0] {
    RS_QADDR = 2'd0,
    RS_TAIL  = 2'd1,
    RS_CTRL  = 2'd2,
    RS_STAT  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [WORD_W-1:0] hi;
    logic [WORD_W-1:0] lo;
  } dsc_t;

  function automatic logic type_ok(input logic [TYPE_W-1:0] t);
    return (t >= TYPE_W'(TYPE_LO)) && (t <= TYPE_W'(TYPE_HI));
  endfunction

endpackage

// File: rtl/invq_regs.sv
module invq_regs
  import invq_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int MAX_QS = 7,
  localparam int IDX_W = MAX_QS + QS_BASE,
  localparam int OFF_W = IDX_W + ENT_SH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic              fault_set,
  output logic [ADDR_W-1:0] base_addr,
  output logic [IDX_W-1:0]  idx_mask,
  output logic              ring_clr,
  output logic [IDX_W-1:0]  tail_idx,
  output logic              q_en,
  output logic              fault
);

  logic [ADDR_W-PAGE_SH-1:0] base_q;
  logic [QS_W-1:0]           qs_q;
  logic [QS_W-1:0]           qs_in;
  logic [IDX_W-1:0]          tail_q;
  logic                      en_q;
  logic                      fault_q;
  logic                      wr_qaddr, wr_tail, wr_ctrl, fault_clr;
  logic                      unused_wdata;

  assign wr_qaddr  = reg_wr && (reg_sel == RS_QADDR);
  assign wr_tail   = reg_wr && (reg_sel == RS_TAIL);
  assign wr_ctrl   = reg_wr && (reg_sel == RS_CTRL);
  assign fault_clr = reg_wr && (reg_sel == RS_STAT) && reg_wdata[0];

  assign qs_in = (reg_wdata[QS_W-1:0] > QS_W'(MAX_QS)) ? QS_W'(MAX_QS)
                                                       : reg_wdata[QS_W-1:0];

  assign unused_wdata = ^{reg_wdata[WORD_W-1:ADDR_W], reg_wdata[PAGE_SH-1:QS_W],
                          reg_wdata[ENT_SH-1:0], reg_wdata[WORD_W-1:OFF_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      qs_q    <= '0;
      tail_q  <= '0;
      en_q    <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      if (wr_qaddr) begin
        base_q <= reg_wdata[ADDR_W-1:PAGE_SH];
        qs_q   <= qs_in;
        tail_q <= '0;
      end else if (wr_tail) begin
        tail_q <= reg_wdata[OFF_W-1:ENT_SH] & idx_mask;
      end
      if (wr_ctrl) en_q <= reg_wdata[0];
      if (fault_set)      fault_q <= 1'b1;
      else if (fault_clr) fault_q <= 1'b0;
    end
  end

  // ring-size mask, one bit per index position
  for (genvar g = 0; g < IDX_W; g++) begin : g_mask
    assign idx_mask[g] = (g < (int'(qs_q) + QS_BASE));
  end

  assign base_addr = {base_q, {PAGE_SH{1'b0}}};
  assign ring_clr  = wr_qaddr;
  assign tail_idx  = tail_q;
  assign q_en      = en_q;
  assign fault     = fault_q;

  // R9
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fault_q) && !$past(fault_clr) |-> fault_q);

  // R8
  fault_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_q) |-> $past(fault_set));

  // R3
  tail_in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_tail) && !$past(wr_qaddr) |-> (tail_q & ~$past(idx_mask)) == '0);

endmodule

// File: rtl/invq_head.sv
module invq_head
  import invq_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int MAX_QS = 7,
  localparam int IDX_W = MAX_QS + QS_BASE,
  localparam int OFF_W = IDX_W + ENT_SH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ring_clr,
  input  logic              adv,
  input  logic [IDX_W-1:0]  idx_mask,
  input  logic [ADDR_W-1:0] base_addr,
  output logic [IDX_W-1:0]  head_idx,
  output logic [OFF_W-1:0]  head_off,
  output logic [ADDR_W-1:0] rd_addr
);

  logic [IDX_W-1:0] head_q;
  logic [IDX_W-1:0] head_inc;

  assign head_inc = (head_q + 1'b1) & idx_mask;

  always_ff @(posedge clk) begin
    if (!rst_n)        head_q <= '0;
    else if (ring_clr) head_q <= '0;
    else if (adv)      head_q <= head_inc;
  end

  assign head_idx = head_q;
  assign head_off = {head_q, {ENT_SH{1'b0}}};
  assign rd_addr  = base_addr + ADDR_W'(head_off);

  // R7
  head_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (head_q != $past(head_q)) && !$past(ring_clr)
      |-> head_q == (($past(head_q) + 1'b1) & $past(idx_mask)));

  // R7
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(adv) && !$past(ring_clr) |-> $stable(head_q));

endmodule

// File: rtl/invq_fsm.sv
module invq_fsm
  import invq_pkg::*;
#(
  parameter int MAX_QS = 7,
  localparam int IDX_W = MAX_QS + QS_BASE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             q_en,
  input  logic             fault,
  input  logic [IDX_W-1:0] head_idx,
  input  logic [IDX_W-1:0] tail_idx,
  input  logic             mem_req_rdy,
  input  logic             mem_rsp_vld,
  input  logic [DSC_W-1:0] mem_rsp_data,
  input  logic             dsc_ready,
  output logic             mem_req,
  output logic             dsc_valid,
  output dsc_t             dsc_out,
  output logic             fault_set,
  output logic             adv
);

  fetch_st_e st_q, st_n;
  dsc_t      dsc_q;
  dsc_t      rsp;
  logic      can_go;
  logic      rsp_take;

  assign rsp      = dsc_t'(mem_rsp_data);
  assign can_go   = q_en && !fault && (head_idx != tail_idx);
  assign rsp_take = (st_q == FS_WAIT) && mem_rsp_vld;

  always_comb begin
    st_n = st_q;
    unique case (st_q)
      FS_IDLE: if (can_go)      st_n = FS_REQ;
      FS_REQ:  if (mem_req_rdy) st_n = FS_WAIT;
      FS_WAIT: if (mem_rsp_vld) st_n = type_ok(rsp.lo[TYPE_W-1:0]) ? FS_SEND : FS_IDLE;
      FS_SEND: if (dsc_ready)   st_n = FS_IDLE;
      default:                  st_n = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= FS_IDLE;
      dsc_q <= '0;
    end else begin
      st_q <= st_n;
      if (rsp_take) dsc_q <= rsp;
    end
  end

  assign mem_req   = (st_q == FS_REQ);
  assign dsc_valid = (st_q == FS_SEND);
  assign dsc_out   = dsc_q;
  assign fault_set = rsp_take && !type_ok(rsp.lo[TYPE_W-1:0]);
  assign adv       = (st_q == FS_SEND) && dsc_ready;

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_req_rdy |=> mem_req);

  // R6
  dsc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dsc_valid && !dsc_ready |=> dsc_valid && $stable(dsc_q));

  // R8
  legal_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dsc_valid |-> type_ok(dsc_q.lo[TYPE_W-1:0]));

  // R8
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !mem_req && !dsc_valid);

  // R4
  one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_req_rdy |=> !mem_req);

endmodule

// File: rtl/invq_fetcher.sv
module invq_fetcher
  import invq_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int MAX_QS = 7,
  localparam int IDX_W = MAX_QS + QS_BASE,
  localparam int OFF_W = IDX_W + ENT_SH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [63:0]       reg_wdata,
  output logic [OFF_W-1:0]  head_off,
  output logic [OFF_W-1:0]  tail_off,
  output logic              fault,
  output logic              mem_req,
  input  logic              mem_req_rdy,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rsp_vld,
  input  logic [127:0]      mem_rsp_data,
  output logic              dsc_valid,
  input  logic              dsc_ready,
  output logic [3:0]        dsc_type,
  output logic [63:0]       dsc_lo,
  output logic [63:0]       dsc_hi
);

  logic [ADDR_W-1:0] base_addr;
  logic [IDX_W-1:0]  idx_mask;
  logic [IDX_W-1:0]  tail_idx;
  logic [IDX_W-1:0]  head_idx;
  logic              ring_clr, q_en, fault_set, adv;
  dsc_t              dsc_out;

  invq_regs #(.ADDR_W(ADDR_W), .MAX_QS(MAX_QS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .fault_set (fault_set),
    .base_addr (base_addr),
    .idx_mask  (idx_mask),
    .ring_clr  (ring_clr),
    .tail_idx  (tail_idx),
    .q_en      (q_en),
    .fault     (fault)
  );

  invq_head #(.ADDR_W(ADDR_W), .MAX_QS(MAX_QS)) u_head (
    .clk       (clk),
    .rst_n     (rst_n),
    .ring_clr  (ring_clr),
    .adv       (adv),
    .idx_mask  (idx_mask),
    .base_addr (base_addr),
    .head_idx  (head_idx),
    .head_off  (head_off),
    .rd_addr   (mem_addr)
  );

  invq_fsm #(.MAX_QS(MAX_QS)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .q_en         (q_en),
    .fault        (fault),
    .head_idx     (head_idx),
    .tail_idx     (tail_idx),
    .mem_req_rdy  (mem_req_rdy),
    .mem_rsp_vld  (mem_rsp_vld),
    .mem_rsp_data (mem_rsp_data),
    .dsc_ready    (dsc_ready),
    .mem_req      (mem_req),
    .dsc_valid    (dsc_valid),
    .dsc_out      (dsc_out),
    .fault_set    (fault_set),
    .adv          (adv)
  );

  assign tail_off = {tail_idx, {ENT_SH{1'b0}}};
  assign dsc_lo   = dsc_out.lo;
  assign dsc_hi   = dsc_out.hi;
  assign dsc_type = dsc_out.lo[TYPE_W-1:0];

  // R2
  ring_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ring_clr) |-> head_off == '0 && tail_off == '0);

endmodule

// File: tb/test_invq_fetcher.sv
module test_invq_fetcher;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0;
  logic [1:0]   reg_sel = 2'd0;
  logic [63:0]  reg_wdata = '0;
  logic [18:0]  head_off, tail_off;
  logic         fault, mem_req, dsc_valid;
  logic         mem_req_rdy = 1'b0;
  logic [47:0]  mem_addr;
  logic         mem_rsp_vld = 1'b0;
  logic [127:0] mem_rsp_data = '0;
  logic         dsc_ready = 1'b0;
  logic [3:0]   dsc_type;
  logic [63:0]  dsc_lo, dsc_hi;

  always #2 clk = ~clk;

  invq_fetcher i_invq_fetcher (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .head_off(head_off), .tail_off(tail_off), .fault(fault),
    .mem_req(mem_req), .mem_req_rdy(mem_req_rdy), .mem_addr(mem_addr),
    .mem_rsp_vld(mem_rsp_vld), .mem_rsp_data(mem_rsp_data),
    .dsc_valid(dsc_valid), .dsc_ready(dsc_ready), .dsc_type(dsc_type),
    .dsc_lo(dsc_lo), .dsc_hi(dsc_hi)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // behavioural model state
  int          m_st = 0;       // 0 idle, 1 request, 2 waiting, 3 offering
  int          m_head = 0, m_tail = 0, m_qs = 0;
  longint      m_base = 0;
  bit          m_en = 0, m_fault = 0;
  logic [127:0] m_dsc = '0;
  int          rsp_cnt = -1;
  longint      rsp_addr = 0;
  int          n_disp = 0;
  logic [3:0]  bad_type [longint];

  bit          pend_wr = 0;
  logic [1:0]  pend_sel = 0;
  logic [63:0] pend_data = 0;

  function automatic int ring_mask(int qs);
    return (1 << (qs + 8)) - 1;
  endfunction

  function automatic logic [127:0] mk_dsc(longint a);
    logic [3:0]  t;
    logic [47:0] a48;
    a48 = a[47:0];
    if (bad_type.exists(a)) t = bad_type[a];
    else t = 4'(1 + ((a >> 4) % 5));
    return {~{16'h0, a48}, {12'h0, a48, t}};
  endfunction

  function automatic bit legal(logic [3:0] t);
    return (t >= 4'd1) && (t <= 4'd5);
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_outputs();
    longint ea;
    ea = m_base + longint'(m_head) * 16;
    check(mem_req === (m_st == 1), "R4", "mem_req", longint'(mem_req), longint'(m_st == 1));
    if (m_st == 1)
      check(mem_addr === ea[47:0], "R4", "mem_addr", longint'(mem_addr), ea);
    check(dsc_valid === (m_st == 3), "R6", "dsc_valid", longint'(dsc_valid), longint'(m_st == 3));
    if (m_st == 3) begin
      check(dsc_lo === m_dsc[63:0], "R6", "dsc_lo", longint'(dsc_lo), longint'(m_dsc[63:0]));
      check(dsc_hi === m_dsc[127:64], "R6", "dsc_hi", longint'(dsc_hi), longint'(m_dsc[127:64]));
      check(dsc_type === m_dsc[3:0], "R6", "dsc_type", longint'(dsc_type), longint'(m_dsc[3:0]));
    end
    check(fault === m_fault, "R8", "fault", longint'(fault), longint'(m_fault));
    check(head_off === 19'(m_head * 16), "R7", "head_off", longint'(head_off), longint'(m_head * 16));
    check(tail_off === 19'(m_tail * 16), "R3", "tail_off", longint'(tail_off), longint'(m_tail * 16));
  endtask

  task automatic model_step();
    int  n_st;
    bit  adv, fset;
    int  mk;
    n_st = m_st; adv = 0; fset = 0;
    mk = ring_mask(m_qs);
    if (rsp_cnt > 0) rsp_cnt--;
    case (m_st)
      0: if (m_en && !m_fault && m_head != m_tail) n_st = 1;
      1: if (mem_req_rdy) begin
           n_st = 2;
           rsp_cnt = $urandom % 3;
           rsp_addr = m_base + longint'(m_head) * 16;
         end
      2: if (mem_rsp_vld) begin
           rsp_cnt = -1;
           if (legal(mem_rsp_data[3:0])) begin m_dsc = mem_rsp_data; n_st = 3; end
           else begin fset = 1; n_st = 0; end
         end
      3: if (dsc_ready) begin adv = 1; n_st = 0; n_disp++; end
      default: n_st = 0;
    endcase
    m_st = n_st;
    if (fset) m_fault = 1;
    else if (reg_wr && reg_sel == 2'd3 && reg_wdata[0]) m_fault = 0;
    if (reg_wr && reg_sel == 2'd0) begin
      m_head = 0; m_tail = 0;
      m_qs = int'(reg_wdata[2:0]);
      m_base = longint'(reg_wdata[47:12]) << 12;
    end else begin
      if (adv) m_head = (m_head + 1) & mk;
      if (reg_wr && reg_sel == 2'd1) m_tail = int'(reg_wdata[18:4]) & mk;
    end
    if (reg_wr && reg_sel == 2'd2) m_en = reg_wdata[0];
  endtask

  task automatic tick();
    @(negedge clk);
    compare_outputs();
    reg_wr = pend_wr; reg_sel = pend_sel; reg_wdata = pend_data;
    pend_wr = 0;
    mem_req_rdy = ($urandom % 4) != 0;
    dsc_ready   = ($urandom % 3) != 0;
    mem_rsp_vld = (rsp_cnt == 0);
    mem_rsp_data = (rsp_cnt == 0) ? mk_dsc(rsp_addr) : '0;
    @(posedge clk);
    model_step();
  endtask

  task automatic wr(logic [1:0] sel, logic [63:0] d);
    pend_wr = 1; pend_sel = sel; pend_data = d;
    tick();
  endtask

  task automatic drain();
    for (int i = 0; i < 20000; i++) begin
      tick();
      if (m_st == 0 && (m_head == m_tail || m_fault || !m_en)) break;
    end
    tick();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    longint b1, b2;
    int d0;
    logic [18:0] h_snap;
    b1 = 64'h0000_1234_5000;
    b2 = 64'h0000_8765_4000;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(head_off == 0 && tail_off == 0, "R1", "offsets after reset", longint'(head_off), 0);
    check(!fault && !mem_req && !dsc_valid, "R1", "flags after reset",
          longint'({fault, mem_req, dsc_valid}), 0);
    rst_n = 1'b1;
    tick();

    // R2 program ring of 256 entries; R4 enable and fetch five entries
    wr(2'd0, b1 | 64'd0);
    wr(2'd2, 64'd1);
    tick();
    check(head_off == 0 && tail_off == 0, "R2", "head/tail after queue address write",
          longint'(head_off), 0);
    d0 = n_disp;
    wr(2'd1, 64'd5 << 4);
    drain();
    check(head_off == 19'h50, "R7", "head after five dispatches", longint'(head_off), 'h50);
    check(n_disp - d0 == 5, "R6", "dispatch count", longint'(n_disp - d0), 5);

    // R8 illegal types at entries 8 (type 0) and 12 (type 6)
    bad_type[b1 + 8*16]  = 4'd0;
    bad_type[b1 + 12*16] = 4'd6;
    wr(2'd1, 64'd14 << 4);
    drain();
    check(fault === 1'b1, "R8", "fault on type 0", longint'(fault), 1);
    check(head_off == 19'h80, "R8", "head stays on bad entry", longint'(head_off), 'h80);
    for (int i = 0; i < 20; i++) tick();
    check(head_off == 19'h80 && fault, "R8", "queue frozen while faulted", longint'(head_off), 'h80);

    // R9 repair and clear, next fault at 12
    bad_type.delete(b1 + 8*16);
    wr(2'd3, 64'd1);
    drain();
    check(head_off == 19'hC0 && fault, "R9", "resumed then faulted at type 6",
          longint'(head_off), 'hC0);
    bad_type.delete(b1 + 12*16);
    wr(2'd3, 64'd1);
    drain();
    check(head_off == 19'(14*16) && !fault, "R9", "drained after second clear",
          longint'(head_off), 14*16);

    // R10 disable mid-stream
    wr(2'd1, 64'd24 << 4);
    for (int i = 0; i < 6; i++) tick();
    wr(2'd2, 64'd0);
    drain();
    h_snap = head_off;
    for (int i = 0; i < 12; i++) tick();
    check(head_off == h_snap && head_off < 19'(24*16), "R10", "no fetch while disabled",
          longint'(head_off), longint'(h_snap));
    wr(2'd2, 64'd1);
    drain();
    check(head_off == 19'(24*16), "R10", "re-enabled drain", longint'(head_off), 24*16);

    // R3 tail index above ring size is dropped: 300 -> 44
    wr(2'd1, 64'd300 << 4);
    tick();
    check(tail_off == 19'(44*16), "R3", "masked tail", longint'(tail_off), 44*16);
    drain();
    check(head_off == 19'(44*16), "R3", "head reaches masked tail", longint'(head_off), 44*16);

    // R11 wrap past the last entry
    d0 = n_disp;
    wr(2'd1, 64'd3 << 4);
    drain();
    check(head_off == 19'h30, "R11", "head after wrap", longint'(head_off), 'h30);
    check(n_disp - d0 == 215, "R11", "dispatches across wrap", longint'(n_disp - d0), 215);

    // R2 reprogram with 512-entry ring at a new base
    wr(2'd0, b2 | 64'd1);
    tick();
    check(head_off == 0 && tail_off == 0, "R2", "reprogram clears pointers", longint'(head_off), 0);
    wr(2'd1, 64'd300 << 4);
    tick();
    check(tail_off == 19'(300*16), "R2", "512-entry ring keeps index 300", longint'(tail_off), 300*16);
    wr(2'd1, 64'd2 << 4);
    drain();
    check(head_off == 19'h20, "R4", "fetch from new base", longint'(head_off), 'h20);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule